// File: doc/BRIEF.md
# Mode-Driven Message Playback Sequencer

This block steps a row pointer through a message memory. Each row carries one end-of-message mark bit. A host, or fixed wiring, drives the block through a chip-enable line, a power-down line, a play/record select and one address bus. A falling edge on chip enable starts an operation. When the two most significant address bits are both high, the address is not used as a start row. Instead the low six bits are taken as mode flags that change how the pointer moves.

The mode flags select five behaviours:
- **cue**: skip ahead to the next message without playing it.
- **merge**: when recording, overwrite the previous end mark so that successive takes join into one message.
- **loop**: repeat the first message without end.
- **consec**: keep the pointer after an end mark, so the next playback continues with the following message.
- **lvl**: playback runs only while chip enable is held low.

Combinations that cannot work together are refused and flagged. The block moves one row per clock. The memory is external, and the block reaches it through an address, a write strobe, a write mark bit and a read mark bit.

Top module: `msq_sequencer`

## Requirements
- R1: An operation starts on a falling edge of `ce_n` that arrives while the block is idle, `pd` is low and no overflow lock is held. If `addr_mode[7:6]` are not both 1, the start row is `addr_mode` and every mode flag is off. If both are 1, the flags are latched from `addr_mode[5:0]` and stay in force until the next accepted start. The bit positions are: cue=bit0, merge=bit1, reserved=bit2, loop=bit3, consec=bit4, lvl=bit5.
- R2: In mode space, the first start after reset or power-down begins at row 0. A start whose play/record direction differs from the previous start also begins at row 0.
- R3: Playback (`play_rec`=1) shows one row per clock on `row_addr_o`, with `row_play_o` high. On a row whose mark is set, it raises `eom_pulse_o` for that cycle, stops, and returns the pointer to 0. Without lvl, the level of `ce_n` after the start has no effect.
- R4: With consec, a playback that ends on a mark leaves the pointer at the following row. The next start then continues from there.
- R5: With cue and playback selected, rows are stepped with `row_play_o` low. `eom_pulse_o` is raised on the first marked row, and the pointer is left on the row after it.
- R6: A merge record that is not the first in its sequence, with the pointer not at 0, starts one row back. It overwrites the previous mark with data, so the two takes play as one message.
- R7: With loop, playback starts at row 0. After a marked row or the last row it continues at row 0, and neither `eom_pulse_o` nor `ovf_pulse_o` is ever raised.
- R8: With lvl, playback ends in the first cycle that `ce_n` is high, with no row shown in that cycle. A new start begins at row 0 unless consec is also set, in which case it resumes at the row where it stopped.
- R9: Recording (`play_rec`=0) writes one row per clock with mark 0 while `ce_n` stays low. In the cycle `ce_n` is high, it writes mark 1 at the current row and leaves the pointer after that row. Consecutive records in mode space follow on from each other.
- R10: If playback, cueing or recording leaves the last row without having ended, `ovf_pulse_o` is raised with that row on `row_addr_o`. The operation then stops, and later starts are ignored until `pd` is raised.
- R11: A mode-space start with the reserved bit set, or with cue+merge, cue+loop or loop+consec, sets `mode_err_o` and performs nothing. The flag is re-evaluated on each later falling edge that is seen while idle.
- R12: While `pd` is high the block is idle, falling edges are ignored, and the pointer is 0. An active record writes its mark first. The overflow lock is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low chip enable; falling edge starts an operation |
| pd | input | 1 | Power-down: stop and rewind |
| play_rec | input | 1 | 1 = playback, 0 = record, sampled at start |
| addr_mode | input | ADDR_W | Start row, or mode flags when the top two bits are 1 |
| row_addr_o | output | ADDR_W | Current row pointer to the memory |
| row_mark_i | input | 1 | Mark bit read from the addressed row |
| row_we_o | output | 1 | Write strobe for the addressed row |
| row_mark_o | output | 1 | Mark bit to write |
| row_play_o | output | 1 | The addressed row is being played this cycle |
| eom_pulse_o | output | 1 | One-cycle end-of-message indication |
| ovf_pulse_o | output | 1 | One-cycle end-of-array indication |
| busy_o | output | 1 | An operation is running |
| mode_err_o | output | 1 | Last evaluated mode set was illegal |

## Verification
The assertions check the following on every cycle:
- Playback steps by exactly one row.
- Looping never raises an end or overflow pulse, and cueing never marks a row as played.
- Writes occur only while recording.
- Power-down leaves the pointer at 0.
- An illegal mode set or an overflow lock keeps the block idle.

Only the bench scenarios can show that the pointer rules add up correctly across a sequence of operations. These include resuming after consec or a level stop, joining merged takes, restarting on a direction change, and cueing onto the right message. The scenarios check this by comparing the full stream of played rows and end pulses against an expected list.

// File: rtl/msq_pkg.sv
package msq_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_PLAY, ST_CUE, ST_REC} st_e;

  typedef enum logic [2:0] {PC_HOLD, PC_LOAD, PC_INC, PC_DEC, PC_CLR} pcmd_e;

  typedef enum logic [1:0] {SR_KEEP, SR_ZERO, SR_BACK} srule_e;

  // flag order follows the bus bit positions: lvl=5 ... cue=0
  typedef struct packed {
    logic lvl;
    logic consec;
    logic loop;
    logic rsv;
    logic merge;
    logic cue;
  } mode_t;

  function automatic logic mode_is_legal(input mode_t m);
    return !(m.rsv || (m.cue && m.merge) || (m.cue && m.loop) || (m.loop && m.consec));
  endfunction

  function automatic srule_e start_rule(input logic fresh, input logic dir_flip,
                                        input logic play, input logic at_zero,
                                        input mode_t m);
    if (fresh || dir_flip) return SR_ZERO;
    if (play && (m.loop || (m.lvl && !m.consec))) return SR_ZERO;
    if (!play && m.merge && !at_zero) return SR_BACK;
    return SR_KEEP;
  endfunction

endpackage

// File: rtl/msq_ce_edge.sv
module msq_ce_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  output logic fall_o
);
  logic ce_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ce_q <= 1'b1;
    else        ce_q <= ce_n;
  end

  assign fall_o = ce_q & ~ce_n;

endmodule

// File: rtl/msq_mode_decode.sv
module msq_mode_decode
  import msq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              mode_space_o,
  output mode_t             mode_o,
  output logic              legal_o
);
  localparam int MODE_BITS = $bits(mode_t);

  assign mode_space_o = &addr_i[ADDR_W-1 -: 2];
  assign mode_o       = mode_t'(addr_i[MODE_BITS-1:0]);
  assign legal_o      = mode_is_legal(mode_o);

endmodule

// File: rtl/msq_row_ptr.sv
module msq_row_ptr
  import msq_pkg::*;
#(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pcmd_e            cmd_i,
  input  logic [ROW_W-1:0] load_i,
  output logic [ROW_W-1:0] ptr_o,
  output logic             at_last_o
);
  localparam logic [ROW_W-1:0] LAST_ROW = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_o <= '0;
    else begin
      case (cmd_i)
        PC_LOAD: ptr_o <= load_i;
        PC_INC:  ptr_o <= ptr_o + 1'b1;
        PC_DEC:  ptr_o <= ptr_o - 1'b1;
        PC_CLR:  ptr_o <= '0;
        default: ptr_o <= ptr_o;
      endcase
    end
  end

  assign at_last_o = (ptr_o == LAST_ROW);

  a_r2_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == PC_CLR) |=> (ptr_o == '0));

endmodule

// File: rtl/msq_sequencer.sv
module msq_sequencer
  import msq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              pd,
  input  logic              play_rec,
  input  logic [ADDR_W-1:0] addr_mode,
  output logic [ADDR_W-1:0] row_addr_o,
  input  logic              row_mark_i,
  output logic              row_we_o,
  output logic              row_mark_o,
  output logic              row_play_o,
  output logic              eom_pulse_o,
  output logic              ovf_pulse_o,
  output logic              busy_o,
  output logic              mode_err_o
);
  localparam int ROW_W = ADDR_W;

  logic             ce_fall;
  logic             mode_space_w;
  mode_t            mode_w;
  logic             legal_w;
  st_e              st_q, st_d;
  mode_t            mode_q;
  logic             fresh_q, dir_q, full_q, err_q;
  pcmd_e            pcmd;
  logic [ROW_W-1:0] ptr;
  logic             at_last;
  logic             set_full;
  logic             start_req, start_ok;
  srule_e           srule;

  msq_ce_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .fall_o (ce_fall)
  );

  msq_mode_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i       (addr_mode),
    .mode_space_o (mode_space_w),
    .mode_o       (mode_w),
    .legal_o      (legal_w)
  );

  msq_row_ptr #(.ROW_W(ROW_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_i     (pcmd),
    .load_i    (addr_mode),
    .ptr_o     (ptr),
    .at_last_o (at_last)
  );

  // named events for assertions
  assign start_req = ce_fall & ~pd & (st_q == ST_IDLE) & ~full_q;
  assign start_ok  = start_req & (~mode_space_w | legal_w);
  assign srule     = start_rule(fresh_q, play_rec != dir_q, play_rec, ptr == '0, mode_w);

  always_comb begin
    st_d        = st_q;
    pcmd        = PC_HOLD;
    row_we_o    = 1'b0;
    row_mark_o  = 1'b0;
    row_play_o  = 1'b0;
    eom_pulse_o = 1'b0;
    ovf_pulse_o = 1'b0;
    set_full    = 1'b0;
    if (pd) begin
      st_d = ST_IDLE;
      pcmd = PC_CLR;
      if (st_q == ST_REC) begin
        row_we_o   = 1'b1;
        row_mark_o = 1'b1;
      end
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_ok) begin
            if (!mode_space_w) pcmd = PC_LOAD;
            else begin
              case (srule)
                SR_ZERO: pcmd = PC_CLR;
                SR_BACK: pcmd = PC_DEC;
                default: pcmd = PC_HOLD;
              endcase
            end
            if (!play_rec)                         st_d = ST_REC;
            else if (mode_space_w && mode_w.cue)   st_d = ST_CUE;
            else                                   st_d = ST_PLAY;
          end
        end
        ST_PLAY: begin
          if (mode_q.lvl && ce_n) begin
            st_d = ST_IDLE;
          end else begin
            row_play_o = 1'b1;
            if (row_mark_i) begin
              if (mode_q.loop) pcmd = PC_CLR;
              else begin
                eom_pulse_o = 1'b1;
                st_d        = ST_IDLE;
                pcmd        = mode_q.consec ? PC_INC : PC_CLR;
              end
            end else if (at_last) begin
              if (mode_q.loop) pcmd = PC_CLR;
              else begin
                ovf_pulse_o = 1'b1;
                set_full    = 1'b1;
                st_d        = ST_IDLE;
              end
            end else begin
              pcmd = PC_INC;
            end
          end
        end
        ST_CUE: begin
          if (row_mark_i) begin
            eom_pulse_o = 1'b1;
            st_d        = ST_IDLE;
            pcmd        = PC_INC;
          end else if (at_last) begin
            ovf_pulse_o = 1'b1;
            set_full    = 1'b1;
            st_d        = ST_IDLE;
          end else begin
            pcmd = PC_INC;
          end
        end
        default: begin
          row_we_o = 1'b1;
          if (ce_n) begin
            row_mark_o = 1'b1;
            st_d       = ST_IDLE;
            pcmd       = PC_INC;
          end else if (at_last) begin
            ovf_pulse_o = 1'b1;
            set_full    = 1'b1;
            st_d        = ST_IDLE;
          end else begin
            pcmd = PC_INC;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      mode_q  <= '0;
      fresh_q <= 1'b1;
      dir_q   <= 1'b1;
      full_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (start_req) err_q <= mode_space_w & ~legal_w;
      if (start_ok) begin
        mode_q  <= mode_space_w ? mode_w : '0;
        dir_q   <= play_rec;
        fresh_q <= 1'b0;
      end
      if (pd) begin
        fresh_q <= 1'b1;
        full_q  <= 1'b0;
      end else if (set_full) begin
        full_q <= 1'b1;
      end
    end
  end

  assign row_addr_o = ptr;
  assign busy_o     = (st_q != ST_IDLE);
  assign mode_err_o = err_q;

  a_r3_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    (row_play_o && !row_mark_i && !at_last && !pd)
      |=> (row_addr_o == $past(row_addr_o) + 1'b1));

  a_r7_loop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PLAY && mode_q.loop) |-> (!eom_pulse_o && !ovf_pulse_o));

  a_r5_cue_no_play: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CUE) |-> !row_play_o);

  a_r8_level_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PLAY && mode_q.lvl && ce_n) |=> !busy_o);

  a_r9_write_in_rec: assert property (@(posedge clk) disable iff (!rst_n)
    row_we_o |-> (st_q == ST_REC));

  a_r10_lock_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !pd) |=> !busy_o);

  a_r11_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err_o |-> !busy_o);

  a_r12_pd_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> (row_addr_o == '0 && !busy_o));

  a_r3_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(eom_pulse_o && ovf_pulse_o));

endmodule

// File: tb/msq_sequencer_tb_top.sv
module msq_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 8;
  localparam int ROWS = 1 << AW;
  localparam logic [AW-1:0] MS = 8'hC0;
  localparam int F_CUE = 1, F_MERGE = 2, F_RSV = 4, F_LOOP = 8, F_CONSEC = 16, F_LVL = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1;
  logic pd = 1'b0;
  logic play_rec = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] row_addr;
  logic row_mark_i, row_we, row_mark_o, row_play, eom_p, ovf_p, busy, merr;
  logic mark_mem [ROWS];

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct { int kind; int row; string req; } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  msq_sequencer #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .pd(pd), .play_rec(play_rec),
    .addr_mode(addr), .row_addr_o(row_addr), .row_mark_i(row_mark_i),
    .row_we_o(row_we), .row_mark_o(row_mark_o), .row_play_o(row_play),
    .eom_pulse_o(eom_p), .ovf_pulse_o(ovf_p), .busy_o(busy), .mode_err_o(merr)
  );

  initial for (int i = 0; i < ROWS; i++) mark_mem[i] = 1'b0;
  always @(posedge clk) if (row_we) mark_mem[row_addr] <= row_mark_o;
  assign row_mark_i = mark_mem[row_addr];

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int kind, input int row, input string req);
    exp_t e;
    e.kind = kind; e.row = row; e.req = req;
    q.push_back(e);
  endtask

  task automatic take(input int kind, input int row);
    exp_t e;
    if (q.size() == 0) begin
      n_cmp++; n_bad++;
      $display("FAIL unexpected event actual=%0d expected=none", kind * 1000 + row);
    end else begin
      e = q.pop_front();
      check(e.req, kind * 1000 + row, e.kind * 1000 + e.row);
    end
  endtask

  // monitor: 0=played row, 1=end mark, 2=overflow
  always @(negedge clk) if (rst_n) begin
    if (row_play) take(0, int'(row_addr));
    if (eom_p)    take(1, int'(row_addr));
    if (ovf_p)    take(2, int'(row_addr));
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
    tick();
  endtask

  task automatic start(input logic pr, input logic [AW-1:0] a);
    play_rec = pr; addr = a; ce_n = 1'b0;
    tick();
    ce_n = 1'b1;
  endtask

  task automatic rec(input logic [AW-1:0] a, input int n);
    play_rec = 1'b0; addr = a; ce_n = 1'b0;
    repeat (n + 1) tick();
    ce_n = 1'b1;
    tick();
  endtask

  task automatic level(input logic [AW-1:0] a, input int k);
    play_rec = 1'b1; addr = a; ce_n = 1'b0;
    repeat (k) tick();
    ce_n = 1'b1;
    tick(); tick();
  endtask

  task automatic pd_pulse();
    pd = 1'b1; tick(); pd = 1'b0; tick();
  endtask

  task automatic play_rows(input int lo, input int hi, input string req);
    for (int r = lo; r <= hi; r++) push(0, r, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    @(negedge clk);
    check("R12 reset busy", busy, 0);
    check("R12 reset row", row_addr, 0);
    check("R11 reset err", merr, 0);
    check("R3 reset play", row_play, 0);
    tick();

    // R9: two plain records in mode space follow on
    rec(MS, 3);
    rec(MS, 2);
    check("R9 mark row3", mark_mem[3], 1);
    check("R9 data row2", mark_mem[2], 0);
    check("R9 mark row6", mark_mem[6], 1);

    // R2/R3: direction change rewinds, edge playback to mark
    play_rows(0, 3, "R2_R3 play"); push(1, 3, "R3 eom");
    start(1'b1, MS); wait_idle();

    // R4: consec resumes after mark
    play_rows(0, 3, "R4 first"); push(1, 3, "R4 eom");
    start(1'b1, MS | F_CONSEC); wait_idle();
    play_rows(4, 6, "R4 second"); push(1, 6, "R4 eom2");
    start(1'b1, MS | F_CONSEC); wait_idle();

    // R5: cue to next message, then consec play
    pd_pulse();
    push(1, 3, "R5 cue eom");
    start(1'b1, MS | F_CUE | F_CONSEC); wait_idle();
    play_rows(4, 6, "R5 after cue"); push(1, 6, "R5 eom");
    start(1'b1, MS | F_CONSEC); wait_idle();

    // R8: level playback, restart and resume
    play_rows(0, 1, "R8 level");
    level(MS | F_LVL, 3);
    play_rows(0, 1, "R8 restart");
    level(MS | F_LVL, 3);
    play_rows(2, 3, "R8 resume"); push(1, 3, "R8 eom");
    level(MS | F_LVL | F_CONSEC, 3);

    // R7: looping under level control
    play_rows(0, 3, "R7 loop a"); play_rows(0, 3, "R7 loop b"); push(0, 0, "R7 loop c");
    level(MS | F_LOOP | F_LVL, 10);
    @(negedge clk); check("R7 stopped", busy, 0); tick();

    // R6: merged takes
    pd_pulse();
    rec(MS | F_MERGE, 1);
    rec(MS | F_MERGE, 1);
    check("R6 old mark cleared", mark_mem[1], 0);
    check("R6 new mark", mark_mem[2], 1);
    play_rows(0, 2, "R6 merged"); push(1, 2, "R6 eom");
    start(1'b1, MS); wait_idle();

    // R11: illegal combinations
    start(1'b1, MS | F_LOOP | F_CONSEC);
    @(negedge clk); check("R11 loop+consec err", merr, 1); check("R11 idle", busy, 0); tick();
    start(1'b1, MS | F_RSV);
    @(negedge clk); check("R11 reserved err", merr, 1); tick();
    start(1'b1, MS | F_CUE | F_MERGE);
    @(negedge clk); check("R11 cue+merge err", merr, 1); tick();
    start(1'b1, MS | F_CUE | F_LOOP);
    @(negedge clk); check("R11 cue+loop err", merr, 1); tick();
    play_rows(0, 2, "R11 legal"); push(1, 2, "R11 eom");
    start(1'b1, MS);
    @(negedge clk); check("R11 err cleared", merr, 0);
    wait_idle();

    // R1: address mode start row
    play_rows(4, 6, "R1 addr"); push(1, 6, "R1 eom");
    start(1'b1, 8'd4); wait_idle();

    // R10: overflow and lock
    play_rows(190, 255, "R10 run"); push(2, 255, "R10 ovf");
    start(1'b1, 8'd190); wait_idle();
    start(1'b1, 8'd4);
    @(negedge clk); check("R10 locked", busy, 0); tick();

    // R12: falls ignored under pd, pd clears lock
    pd = 1'b1; ce_n = 1'b0; tick();
    @(negedge clk); check("R12 pd ignores fall", busy, 0);
    tick(); ce_n = 1'b1; pd = 1'b0; tick();
    play_rows(4, 6, "R12 unlocked"); push(1, 6, "R12 eom");
    start(1'b1, 8'd4); wait_idle();

    repeat (3) tick();
    check("R3 all expected events seen", q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule